// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the write side of a parallel NOR flash whose commands are guarded by a two-cycle unlock handshake. Each bus write cycle carries a byte address and a data word. The sequencer tracks which command cycle it has reached and checks the address and the data of every step in order. It decodes program, identification, erase, unlock-skip, query and abort commands.

It holds the storage array as an internal register file. A program ANDs the written word into the stored word, so bits can only be cleared. Erase sets a whole sector, or the whole array, to all-ones, one word per clock. An erase busy timer runs alongside the fill. The current mode code and a status byte are exported for a separate read responder, which also reads the array through a plain combinational port.

An unlock-skip mode lets later program and erase commands start at the command cycle, without the two unlock writes. It is left by a dedicated exit write or by the abort command.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the mode code is 0 (idle), status is 0x00, the skip flag and busy are low, and every array word reads all-ones.
- R2: From idle, data 0xAA at word offset UNLOCK0 gives mode 1. From mode 1, data 0x55 at offset UNLOCK1 gives mode 2. Any other write in either state returns to mode 0.
- R3: A write whose low data byte is 0xF0 returns to mode 0 and clears the skip flag in every mode except mode 3 (waiting for program data) and mode 8 (erase busy).
- R4: In idle, data 0x98 at word offset 0x55 enters query mode 9. Any write while in mode 9 returns to mode 0.
- R5: In mode 2 the offset must equal UNLOCK0 unless skip is active. Data 0x80 then gives mode 5, 0x90 gives mode 4 and 0xA0 gives mode 3. Any other data, or a wrong offset, gives mode 0.
- R6: In mode 3 the next write ANDs its data into the addressed word. Status becomes {~data[7], 7'h7F}. The mode then becomes 0, or 2 when skip is active.
- R7: In mode 2, data 0x20 sets the skip flag and stays in mode 2. While skip is set, a command write in mode 2 is accepted at any offset.
- R8: In mode 4 with skip set, data 0x00 clears skip and gives mode 0. In mode 4, data 0x98 at offset 0x55 gives mode 9.
- R9: Erase setup walks modes 5, 6 and 7 on 0xAA at UNLOCK0 and then 0x55 at UNLOCK1; in mode 5, 0x98 at offset 0x55 also enters mode 9. In mode 7, 0x10 at UNLOCK0 starts a full-array erase and 0x30 starts an erase of the sector holding the address. Both enter mode 8 with status 0x00. Anything else gives mode 0.
- R10: Mode 8 and busy last exactly SECT_ERASE_CYC cycles for a sector and ten times that for the whole array. Every write in this period is ignored, 0xF0 included. At the end status bit 7 inverts and the mode becomes 0, or 2 when skip is active.
- R11: The word offset is the byte offset within a sector shifted right by log2(DATA_W/8). The sector is taken from the word address bits above the offset.
- R12: A sector erase sets exactly the words of that sector to all-ones and leaves the other sectors unchanged. A full erase sets every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | BA_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; the command byte is bits 7:0 |
| rd_addr | input | WA_W | Word address for the read responder |
| rd_data | output | DATA_W | Array word at rd_addr |
| mode | output | 4 | Current command mode code |
| status | output | 8 | Status byte for the read side |
| bypass | output | 1 | Unlock-skip mode active |
| busy | output | 1 | Erase in progress |

## Verification
The bench builds a 16-bit device, so the byte-to-word shift of R11 is exercised on both odd and even byte addresses. It uses four sectors of 128 words, which keeps word offset 0x55 inside a sector. It uses unlock offsets 0x35 and 0x4A, which differ from the query offset. A 200-cycle sector erase makes the exact busy length of both sector and full-array erase measurable, and a full erase covers all 512 words well inside the run budget.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [3:0] {
        M_IDLE    = 4'd0,
        M_UNLK1   = 4'd1,
        M_CMD     = 4'd2,
        M_PROG    = 4'd3,
        M_IDENT   = 4'd4,
        M_EUNLK0  = 4'd5,
        M_EUNLK1  = 4'd6,
        M_ECMD    = 4'd7,
        M_ERASE   = 4'd8,
        M_QUERY   = 4'd9
    } mode_e;

    localparam logic [7:0] K_UNLK_A   = 8'hAA;
    localparam logic [7:0] K_UNLK_B   = 8'h55;
    localparam logic [7:0] K_ABORT    = 8'hF0;
    localparam logic [7:0] K_QUERY    = 8'h98;
    localparam logic [7:0] K_SKIP     = 8'h20;
    localparam logic [7:0] K_ESETUP   = 8'h80;
    localparam logic [7:0] K_IDENT    = 8'h90;
    localparam logic [7:0] K_PROG     = 8'hA0;
    localparam logic [7:0] K_ERS_ALL  = 8'h10;
    localparam logic [7:0] K_ERS_SECT = 8'h30;
    localparam logic [7:0] K_SKIP_END = 8'h00;

    localparam int QUERY_OFFSET = 'h55;
    localparam int CHIP_FACTOR  = 10;

    typedef struct packed {
        logic prog;
        logic erase;
        logic whole;
    } action_t;

    function automatic logic [7:0] prog_status(input logic d7);
        return {~d7, 7'h7F};
    endfunction

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_seq_pkg::*;
#(
    parameter int OFF_W   = 9,
    parameter int UNLOCK0 = 'h155,
    parameter int UNLOCK1 = 'h0AA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       cmd,
    input  logic             d7,
    input  logic             erase_done,
    output mode_e            mode_q,
    output logic             skip_q,
    output logic [7:0]       status_q,
    output action_t          act
);
    localparam logic [OFF_W-1:0] U0  = OFF_W'(UNLOCK0);
    localparam logic [OFF_W-1:0] U1  = OFF_W'(UNLOCK1);
    localparam logic [OFF_W-1:0] QOF = OFF_W'(QUERY_OFFSET);

    mode_e      mode_d;
    logic       skip_d;
    logic [7:0] status_d;
    logic       abort;
    logic       is_query;

    assign is_query = (off == QOF) && (cmd == K_QUERY);

    always_comb begin
        mode_d   = mode_q;
        skip_d   = skip_q;
        status_d = status_q;
        act      = '0;
        abort    = 1'b0;
        if (mode_q == M_ERASE) begin
            if (erase_done) begin
                status_d[7] = ~status_q[7];
                mode_d      = skip_q ? M_CMD : M_IDLE;
            end
        end else if (wr_en) begin
            if (mode_q != M_PROG && cmd == K_ABORT) begin
                abort = 1'b1;
            end else begin
                case (mode_q)
                    M_IDLE, M_EUNLK0: begin
                        if (is_query)
                            mode_d = M_QUERY;
                        else if (off == U0 && cmd == K_UNLK_A)
                            mode_d = (mode_q == M_IDLE) ? M_UNLK1 : M_EUNLK1;
                        else
                            abort = 1'b1;
                    end
                    M_UNLK1: begin
                        if (off == U1 && cmd == K_UNLK_B) mode_d = M_CMD;
                        else                              abort  = 1'b1;
                    end
                    M_CMD: begin
                        if (!skip_q && off != U0) begin
                            abort = 1'b1;
                        end else begin
                            case (cmd)
                                K_SKIP:   skip_d = 1'b1;
                                K_ESETUP: mode_d = M_EUNLK0;
                                K_IDENT:  mode_d = M_IDENT;
                                K_PROG:   mode_d = M_PROG;
                                default:  abort  = 1'b1;
                            endcase
                        end
                    end
                    M_PROG: begin
                        act.prog = 1'b1;
                        status_d = prog_status(d7);
                        mode_d   = skip_q ? M_CMD : M_IDLE;
                    end
                    M_IDENT: begin
                        if (skip_q && cmd == K_SKIP_END) abort  = 1'b1;
                        else if (is_query)               mode_d = M_QUERY;
                        else                             abort  = 1'b1;
                    end
                    M_EUNLK1: begin
                        if (off == U1 && cmd == K_UNLK_B) mode_d = M_ECMD;
                        else                              abort  = 1'b1;
                    end
                    M_ECMD: begin
                        if ((cmd == K_ERS_ALL && off == U0) || cmd == K_ERS_SECT) begin
                            act.erase = 1'b1;
                            act.whole = (cmd == K_ERS_ALL);
                            status_d  = 8'h00;
                            mode_d    = M_ERASE;
                        end else begin
                            abort = 1'b1;
                        end
                    end
                    default: abort = 1'b1;
                endcase
            end
            if (abort) begin
                mode_d = M_IDLE;
                skip_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= M_IDLE;
            skip_q   <= 1'b0;
            status_q <= 8'h00;
        end else begin
            mode_q   <= mode_d;
            skip_q   <= skip_d;
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine #(
    parameter int WA_W       = 11,
    parameter int OFF_W      = 9,
    parameter int SECT_WORDS = 512,
    parameter int TOTAL      = 2048,
    parameter int SECT_CYC   = 600,
    parameter int CHIP_CYC   = 6000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  whole,
    input  logic [WA_W-OFF_W-1:0] sect,
    output logic                  busy,
    output logic                  done,
    output logic                  fill_en,
    output logic [WA_W-1:0]       fill_addr
);
    localparam int CNT_W  = $clog2(CHIP_CYC + 1);
    localparam int LEFT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0]  timer;
    logic [LEFT_W-1:0] left;
    logic [WA_W-1:0]   ptr;

    assign done      = busy && (timer == '0) && (left == '0);
    assign fill_en   = busy && (left != '0);
    assign fill_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            timer <= '0;
            left  <= '0;
            ptr   <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            timer <= whole ? CNT_W'(CHIP_CYC - 1) : CNT_W'(SECT_CYC - 1);
            left  <= whole ? LEFT_W'(TOTAL) : LEFT_W'(SECT_WORDS);
            ptr   <= whole ? '0 : {sect, {OFF_W{1'b0}}};
        end else if (busy) begin
            if (timer != '0) timer <= timer - 1'b1;
            if (left != '0) begin
                left <= left - 1'b1;
                ptr  <= ptr + 1'b1;
            end
            if (done) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array #(
    parameter int DATA_W = 16,
    parameter int WA_W   = 11,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [WA_W-1:0]   prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              fill_en,
    input  logic [WA_W-1:0]   fill_addr,
    input  logic [WA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (fill_en) mem[fill_addr] <= '1;
            if (prog_en) mem[prog_addr] <= mem[prog_addr] & prog_data;
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int SECT_WORDS     = 512,
    parameter int NUM_SECT       = 4,
    parameter int UNLOCK0        = 'h155,
    parameter int UNLOCK1        = 'h0AA,
    parameter int SECT_ERASE_CYC = 600,
    localparam int BYTES         = DATA_W / 8,
    localparam int BSH           = $clog2(BYTES),
    localparam int TOTAL         = SECT_WORDS * NUM_SECT,
    localparam int OFF_W         = $clog2(SECT_WORDS),
    localparam int WA_W          = $clog2(TOTAL),
    localparam int BA_W          = WA_W + BSH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        mode,
    output logic [7:0]        status,
    output logic              bypass,
    output logic              busy
);
    localparam int CHIP_ERASE_CYC = SECT_ERASE_CYC * CHIP_FACTOR;
    localparam int SW_W           = WA_W - OFF_W;

    logic [WA_W-1:0] word_addr;
    mode_e           mode_q;
    action_t         act;
    logic            erase_done;
    logic            fill_en;
    logic [WA_W-1:0] fill_addr;

    assign word_addr = WA_W'(wr_addr >> BSH);

    nor_cmd_fsm #(
        .OFF_W   (OFF_W),
        .UNLOCK0 (UNLOCK0),
        .UNLOCK1 (UNLOCK1)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .off        (word_addr[OFF_W-1:0]),
        .cmd        (wr_data[7:0]),
        .d7         (wr_data[7]),
        .erase_done (erase_done),
        .mode_q     (mode_q),
        .skip_q     (bypass),
        .status_q   (status),
        .act        (act)
    );

    nor_erase_engine #(
        .WA_W       (WA_W),
        .OFF_W      (OFF_W),
        .SECT_WORDS (SECT_WORDS),
        .TOTAL      (TOTAL),
        .SECT_CYC   (SECT_ERASE_CYC),
        .CHIP_CYC   (CHIP_ERASE_CYC)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (act.erase),
        .whole     (act.whole),
        .sect      (word_addr[WA_W-1:WA_W-SW_W]),
        .busy      (busy),
        .done      (erase_done),
        .fill_en   (fill_en),
        .fill_addr (fill_addr)
    );

    nor_word_array #(
        .DATA_W (DATA_W),
        .WA_W   (WA_W),
        .DEPTH  (TOTAL)
    ) u_arr (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (act.prog),
        .prog_addr (word_addr),
        .prog_data (wr_data),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    assign mode = mode_q;

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk
    import nor_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [3:0]        mode,
    input logic [7:0]        status,
    input logic              bypass,
    input logic              busy
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mode == M_IDLE && status == 8'h00 && !bypass && !busy));

    // R2
    unlock_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == M_UNLK1 && wr_data[7:0] != K_UNLK_B) |=> mode == M_IDLE);

    // R3
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7:0] == K_ABORT && mode != M_PROG && mode != M_ERASE)
        |=> (mode == M_IDLE && !bypass));

    // R4
    query_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == M_QUERY) |=> mode == M_IDLE);

    // R6
    prog_status_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode == M_PROG) |=> (status[6:0] == 7'h7F && status[7] == !$past(wr_data[7])));

    // R7
    skip_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass) |-> mode == M_CMD);

    // R9
    erase_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> status == 8'h00);

    // R10
    busy_mode_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> mode == M_ERASE);

    // R10
    mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_ERASE) |-> busy);

    // R10
    erase_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> status[7] != $past(status[7]));

endmodule

bind nor_cmd_seq nor_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mode    (mode),
    .status  (status),
    .bypass  (bypass),
    .busy    (busy)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 16;
    localparam int BA_W = 10;
    localparam int WA_W = 9;
    localparam int SECT_CYC = 200;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [BA_W-1:0] wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [WA_W-1:0] rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [3:0]      mode;
    logic [7:0]      status;
    logic            bypass;
    logic            busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(
        .DATA_W(16), .SECT_WORDS(128), .NUM_SECT(4),
        .UNLOCK0('h35), .UNLOCK1('h4A), .SECT_ERASE_CYC(SECT_CYC)
    ) u_nor_cmd_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mode(mode), .status(status),
        .bypass(bypass), .busy(busy)
    );

    typedef struct packed {
        logic [9:0]  a;
        logic [15:0] d;
        logic [3:0]  m;
        logic        b;
        logic [3:0]  r;
    } vec_t;

    // byte addresses: unlock0 0x06A, unlock1 0x094, query 0x0AA
    localparam int NV = 37;
    localparam vec_t TBL [NV] = '{
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},   // R2 first unlock
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},   // R2 second unlock
        '{10'h06A, 16'h0090, 4'd4, 1'b0, 4'd5},   // R5 identification
        '{10'h0AA, 16'h0098, 4'd9, 1'b0, 4'd8},   // R8 query from identification
        '{10'h000, 16'h0012, 4'd0, 1'b0, 4'd4},   // R4 write in query
        '{10'h0AA, 16'h0098, 4'd9, 1'b0, 4'd4},   // R4 query from idle
        '{10'h010, 16'h00F0, 4'd0, 1'b0, 4'd3},   // R3 abort from query
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h096, 16'h0055, 4'd0, 1'b0, 4'd2},   // R2 wrong second address
        '{10'h06A, 16'h00AB, 4'd0, 1'b0, 4'd2},   // R2 wrong first data
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},
        '{10'h010, 16'h0090, 4'd0, 1'b0, 4'd5},   // R5 wrong command address
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},
        '{10'h06A, 16'h0077, 4'd0, 1'b0, 4'd5},   // R5 unknown command
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},
        '{10'h06A, 16'h0020, 4'd2, 1'b1, 4'd7},   // R7 enter skip
        '{10'h010, 16'h0090, 4'd4, 1'b1, 4'd7},   // R7 any address accepted
        '{10'h000, 16'h0000, 4'd0, 1'b0, 4'd8},   // R8 skip exit
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},
        '{10'h06A, 16'h0020, 4'd2, 1'b1, 4'd7},
        '{10'h002, 16'h00F0, 4'd0, 1'b0, 4'd3},   // R3 abort clears skip
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},
        '{10'h06A, 16'h0080, 4'd5, 1'b0, 4'd5},   // R5 erase setup
        '{10'h06A, 16'h00AA, 4'd6, 1'b0, 4'd9},   // R9 second unlock
        '{10'h094, 16'h0055, 4'd7, 1'b0, 4'd9},
        '{10'h06A, 16'h0055, 4'd0, 1'b0, 4'd9},   // R9 bad erase command
        '{10'h06A, 16'h00AA, 4'd1, 1'b0, 4'd2},
        '{10'h094, 16'h0055, 4'd2, 1'b0, 4'd2},
        '{10'h06A, 16'h0080, 4'd5, 1'b0, 4'd5},
        '{10'h06A, 16'h00AA, 4'd6, 1'b0, 4'd9},
        '{10'h094, 16'h0055, 4'd7, 1'b0, 4'd9},
        '{10'h010, 16'h0010, 4'd0, 1'b0, 4'd9}    // R9 full erase off unlock0
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [BA_W-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int word, output logic [DW-1:0] v);
        rd_addr = WA_W'(word);
        #1;
        v = rd_data;
    endtask

    task automatic prog(input logic [BA_W-1:0] a, input logic [DW-1:0] d);
        wr(10'h06A, 16'h00AA);
        wr(10'h094, 16'h0055);
        wr(10'h06A, 16'h00A0);
        wr(a, d);
    endtask

    task automatic erase_setup();
        wr(10'h06A, 16'h00AA);
        wr(10'h094, 16'h0055);
        wr(10'h06A, 16'h0080);
        wr(10'h06A, 16'h00AA);
        wr(10'h094, 16'h0055);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(1, "mode", mode, 0);
        check(1, "status", status, 8'h00);
        check(1, "bypass", bypass, 0);
        check(1, "busy", busy, 0);
        rd(300, v);
        check(1, "array", v, 16'hFFFF);

        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].a, TBL[i].d);
            check(TBL[i].r, $sformatf("vec %0d mode", i), mode, TBL[i].m);
            check(TBL[i].r, $sformatf("vec %0d bypass", i), bypass, TBL[i].b);
        end

        // R6 program AND and status
        prog(10'h020, 16'h1234);
        check(6, "mode after prog", mode, 0);
        check(6, "status d7=0", status, 8'hFF);
        rd(16, v);
        check(6, "word 16", v, 16'h1234);
        prog(10'h020, 16'h0F80);
        check(6, "status d7=1", status, 8'h7F);
        rd(16, v);
        check(6, "word 16 and", v, 16'h0200);
        // R3 abort value is programmed as data in mode 3
        prog(10'h022, 16'h00F0);
        check(3, "mode after F0 data", mode, 0);
        rd(17, v);
        check(3, "word 17", v, 16'h00F0);

        // R7 program under skip returns to mode 2
        wr(10'h06A, 16'h00AA);
        wr(10'h094, 16'h0055);
        wr(10'h06A, 16'h0020);
        wr(10'h000, 16'h00A0);
        check(7, "skip prog mode", mode, 3);
        wr(10'h024, 16'h7F00);
        check(6, "skip prog return", mode, 2);
        check(7, "skip kept", bypass, 1);
        rd(18, v);
        check(6, "word 18", v, 16'h7F00);
        wr(10'h000, 16'h00F0);
        check(3, "abort skip", bypass, 0);

        // R11 byte to word shift and sector offset
        wr(10'h06B, 16'h00AA);
        check(11, "odd byte of unlock0", mode, 1);
        wr(10'h000, 16'h00F0);
        wr(10'h035, 16'h00AA);
        check(11, "unshifted address", mode, 0);
        wr(10'h26A, 16'h00AA);
        check(11, "unlock0 in sector 2", mode, 1);
        wr(10'h000, 16'h00F0);

        // R12 sector erase of sector 1
        prog(10'd266, 16'h0000);
        prog(10'd522, 16'h0000);
        erase_setup();
        wr(10'd280, 16'h0030);
        check(9, "sector erase mode", mode, 8);
        check(9, "erase status", status, 8'h00);
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(10, "sector busy cycles", n, SECT_CYC);
        check(10, "mode after sector", mode, 0);
        check(10, "status flip", status, 8'h80);
        rd(133, v);
        check(12, "sector 1 erased", v, 16'hFFFF);
        rd(261, v);
        check(12, "sector 2 kept", v, 16'h0000);
        rd(16, v);
        check(12, "sector 0 kept", v, 16'h0200);

        // R10 full erase in skip mode, writes ignored
        wr(10'h06A, 16'h00AA);
        wr(10'h094, 16'h0055);
        wr(10'h06A, 16'h0020);
        wr(10'h100, 16'h0080);
        check(7, "skip erase setup", mode, 5);
        wr(10'h06A, 16'h00AA);
        wr(10'h094, 16'h0055);
        wr(10'h06A, 16'h0010);
        check(9, "full erase mode", mode, 8);
        wr(10'h000, 16'h00F0);
        check(10, "abort ignored", mode, 8);
        check(10, "skip kept in erase", bypass, 1);
        n = 0;
        while (busy && n < 50000) begin
            @(negedge clk);
            n++;
        end
        check(10, "full busy cycles", n, SECT_CYC * 10 - 2);
        check(10, "mode after full", mode, 2);
        check(10, "status after full", status, 8'h80);
        rd(261, v);
        check(12, "full erase word 261", v, 16'hFFFF);
        rd(16, v);
        check(12, "full erase word 16", v, 16'hFFFF);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule